// File: doc/BRIEF.md
# Transmit Frame Check Sequence and Padding Stage

This stage sits in a transmit byte stream, between the packet buffer and the serializer. Each packet carries a two-bit finishing code that is taken together with its first byte. Depending on that code, the stage passes the packet through untouched. It can also append a CRC-32 frame check sequence, with or without first zero-padding the packet to a minimum length. Finally, it can drop the packet's final four bytes and put a freshly computed check sequence in their place.

A segmentation flag, also taken with the first byte, overrides the code and always selects the pad-and-append treatment. Both sides use a valid/ready handshake with a last-byte marker. Back-pressure on the output stalls the input. While padding or check-sequence bytes are being produced, the stage accepts no input.

Top module: `tx_fcs_pad_stage`

## Requirements
- R1: Code 2'b00: the packet is forwarded, then zero bytes are added until the packet holds MIN_FRAME (60) bytes, then the 4-byte check sequence is appended; packets of 60 bytes or more receive no zero bytes.
- R2: Code 2'b01: the 4-byte check sequence is appended directly after the packet, with no padding even when the packet is shorter than 60 bytes.
- R3: Code 2'b10: the packet leaves unchanged, with the last marker on its own final byte and nothing added.
- R4: Code 2'b11: the final four input bytes are discarded and replaced by a check sequence computed over all earlier bytes. A packet of four bytes or fewer yields only the check sequence of an empty message, 00 00 00 00.
- R5: The code and segmentation flag are taken only with the first byte of a packet; different values on later bytes have no effect.
- R6: When the segmentation flag is 1 on the first byte, the packet is treated as code 2'b00 regardless of the code.
- R7: The check sequence is the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, result inverted), sent least significant byte first, with the last marker on its fourth byte; "123456789" gives bytes 26 39 F4 CB.
- R8: Output back-pressure loses and repeats no byte, including during padding and check-sequence output, and no input byte is accepted from the packet's last input byte until the last output byte.
- R9: After reset no output is valid, and with the output ready the stage is ready to take the first byte of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Stage accepts the input byte |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Input byte is the packet's final byte |
| s_mode | input | 2 | Finishing code, taken with the first byte |
| s_seg | input | 1 | Segmentation flag, taken with the first byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Output byte ends the packet |

## Verification
The bench goes after the padding edge at 59, 60 and 61 bytes. A length counter that is off by one there yields a 59- or 61-byte body before the check sequence. Replacement packets of one to five bytes show whether the holdback leaks stale bytes or folds dropped bytes into the check. On every packet the code and flag are flipped after the first byte, and any late sampling shows up as the wrong treatment. Irregular output stalls during the padding and check tail would expose a repeated or skipped check byte, or an early acceptance of the next packet's byte.

// File: rtl/tx_fcs_pkg.sv
package tx_fcs_pkg;

   typedef enum logic [1:0] {
      MODE_PAD_FCS = 2'b00,
      MODE_FCS     = 2'b01,
      MODE_RAW     = 2'b10,
      MODE_SWAP    = 2'b11
   } fcs_mode_e;

   typedef enum logic [1:0] {
      ST_BODY = 2'd0,
      ST_FILL = 2'd1,
      ST_TAIL = 2'd2
   } tail_state_e;

   localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB8_8320;

endpackage

// File: rtl/tx_fcs_crc_acc.sv
module tx_fcs_crc_acc #(
   parameter int unsigned         CRC_W = 32,
   parameter logic [CRC_W-1:0]    POLY  = 32'hEDB8_8320,
   parameter int unsigned         SYM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             update,
   input  logic [SYM_W-1:0] din,
   output logic [CRC_W-1:0] fcs
);
   localparam logic [CRC_W-1:0] SEED = '1;

   logic [CRC_W-1:0]             crc_q;
   logic [SYM_W:0][CRC_W-1:0]    chain;

   assign chain[0] = crc_q ^ CRC_W'(din);

   for (genvar g = 0; g < SYM_W; g++) begin : g_bit
      assign chain[g+1] = chain[g][0] ? ((chain[g] >> 1) ^ POLY) : (chain[g] >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= SEED;
      else if (clear)  crc_q <= SEED;
      else if (update) crc_q <= chain[SYM_W];
   end

   assign fcs = ~crc_q;

   initial begin : param_chk
      if (CRC_W < SYM_W) $error("tx_fcs_crc_acc: CRC_W smaller than symbol width");
   end
endmodule

// File: rtl/tx_fcs_holdback.sv
module tx_fcs_holdback #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [DEPTH:0][W-1:0] tap;
   logic [CNT_W-1:0]      fill_q;

   assign tap[0] = din;

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (push) q <= tap[g];
      end
      assign tap[g+1] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               fill_q <= '0;
      else if (clear)           fill_q <= '0;
      else if (push && !full)   fill_q <= fill_q + 1'b1;
   end

   assign full = (fill_q == CNT_FULL);
   assign dout = tap[DEPTH];

   initial begin : param_chk
      if (DEPTH < 1) $error("tx_fcs_holdback: DEPTH must be at least 1");
   end
endmodule

// File: rtl/tx_fcs_len_count.sv
module tx_fcs_len_count #(
   parameter int unsigned MIN_FRAME = 60,
   parameter int unsigned LEN_W     = $clog2(MIN_FRAME + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [LEN_W-1:0] len,
   output logic             short_next
);
   localparam logic [LEN_W:0] MIN_L = (LEN_W + 1)'(MIN_FRAME);

   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              len_q <= '0;
      else if (clear)                          len_q <= '0;
      else if (inc && ({1'b0, len_q} < MIN_L)) len_q <= len_q + 1'b1;
   end

   assign len        = len_q;
   assign short_next = (({1'b0, len_q} + 1'b1) < MIN_L);

   initial begin : param_chk
      if (MIN_FRAME < 1) $error("tx_fcs_len_count: MIN_FRAME must be at least 1");
   end
endmodule

// File: rtl/tx_fcs_pad_stage.sv
module tx_fcs_pad_stage
   import tx_fcs_pkg::*;
#(
   parameter int unsigned      MIN_FRAME = 60,
   parameter int unsigned      CRC_W     = 32,
   parameter logic [CRC_W-1:0] CRC_POLY  = CRC32_POLY_REFL
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       s_valid,
   output logic       s_ready,
   input  logic [7:0] s_data,
   input  logic       s_last,
   input  logic [1:0] s_mode,
   input  logic       s_seg,
   output logic       m_valid,
   input  logic       m_ready,
   output logic [7:0] m_data,
   output logic       m_last
);
   localparam int unsigned FCS_BYTES = CRC_W / 8;
   localparam int unsigned IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
   localparam int unsigned LEN_W     = $clog2(MIN_FRAME + 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

   tail_state_e st_q, st_d;
   fcs_mode_e   mode_q, mode_in, mode_now;
   logic        pkt_q;
   logic [IDX_W-1:0] idx_q;

   logic [CRC_W-1:0]               fcs;
   logic [FCS_BYTES-1:0][7:0]      fcs_b;
   logic [7:0]                     hb_dout;
   logic                           hb_full, hb_push, hb_clear;
   logic [LEN_W-1:0]               len_q;
   logic                           len_short;
   logic                           s_acc, m_emit, body_emit, pkt_end;

   // per-packet code, overridden by the segmentation flag
   assign mode_in  = s_seg ? MODE_PAD_FCS : fcs_mode_e'(s_mode);
   assign mode_now = pkt_q ? mode_q : mode_in;

   assign fcs_b = fcs;

   // datapath steering
   always_comb begin
      s_ready = 1'b0;
      m_valid = 1'b0;
      m_data  = '0;
      m_last  = 1'b0;
      unique case (st_q)
         ST_BODY: begin
            if (mode_now == MODE_SWAP && !hb_full) begin
               s_ready = 1'b1;
            end else begin
               m_valid = s_valid;
               s_ready = m_ready;
               m_data  = (mode_now == MODE_SWAP) ? hb_dout : s_data;
               m_last  = s_last && (mode_now == MODE_RAW);
            end
         end
         ST_FILL: begin
            m_valid = 1'b1;
            m_data  = '0;
         end
         ST_TAIL: begin
            m_valid = 1'b1;
            m_data  = fcs_b[idx_q];
            m_last  = (idx_q == IDX_LAST);
         end
         default: ;
      endcase
   end

   assign s_acc     = s_valid && s_ready;
   assign m_emit    = m_valid && m_ready;
   assign body_emit = m_emit && (st_q != ST_TAIL);
   assign hb_push   = s_acc && (st_q == ST_BODY) && (mode_now == MODE_SWAP);
   assign hb_clear  = hb_push && s_last;

   // sequencing
   always_comb begin
      st_d    = st_q;
      pkt_end = 1'b0;
      unique case (st_q)
         ST_BODY: begin
            if (s_acc && s_last) begin
               unique case (mode_now)
                  MODE_RAW:     pkt_end = 1'b1;
                  MODE_PAD_FCS: st_d = len_short ? ST_FILL : ST_TAIL;
                  default:      st_d = ST_TAIL;
               endcase
            end
         end
         ST_FILL: begin
            if (m_emit && !len_short) st_d = ST_TAIL;
         end
         ST_TAIL: begin
            if (m_emit && idx_q == IDX_LAST) begin
               st_d    = ST_BODY;
               pkt_end = 1'b1;
            end
         end
         default: st_d = ST_BODY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_BODY;
         idx_q  <= '0;
         pkt_q  <= 1'b0;
         mode_q <= MODE_PAD_FCS;
      end else begin
         st_q <= st_d;
         if (st_q == ST_TAIL && m_emit)
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
         if (s_acc) begin
            pkt_q <= !s_last;
            if (!pkt_q) mode_q <= mode_in;
         end
      end
   end

   tx_fcs_crc_acc #(
      .CRC_W (CRC_W),
      .POLY  (CRC_POLY),
      .SYM_W (8)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (pkt_end),
      .update (body_emit),
      .din    (m_data),
      .fcs    (fcs)
   );

   tx_fcs_holdback #(
      .DEPTH (FCS_BYTES),
      .W     (8)
   ) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (hb_clear),
      .push  (hb_push),
      .din   (s_data),
      .dout  (hb_dout),
      .full  (hb_full)
   );

   tx_fcs_len_count #(
      .MIN_FRAME (MIN_FRAME),
      .LEN_W     (LEN_W)
   ) u_len (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (pkt_end),
      .inc        (body_emit),
      .len        (len_q),
      .short_next (len_short)
   );

   initial begin : param_chk
      if (CRC_W == 0 || (CRC_W % 8) != 0)
         $error("tx_fcs_pad_stage: CRC_W must be a non-zero multiple of 8");
   end
endmodule

// File: rtl/tx_fcs_pad_stage_chk.sv
module tx_fcs_pad_stage_chk #(
   parameter int unsigned MIN_FRAME = 60,
   parameter int unsigned LEN_W     = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       st,
   input logic [1:0]       mode,
   input logic             pkt,
   input logic [LEN_W-1:0] len,
   input logic             s_ready,
   input logic             m_valid,
   input logic             m_ready,
   input logic [7:0]       m_data
);
   localparam logic [1:0] C_BODY = 2'd0;
   localparam logic [1:0] C_FILL = 2'd1;
   localparam logic [1:0] C_TAIL = 2'd2;

   AST_TAIL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (st != C_BODY) |-> !s_ready);                                       // R8

   AST_TAIL_HOLDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (st != C_BODY && m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R8

   AST_FILL_ONLY_PAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == C_FILL) |-> (mode == 2'b00));                                // R1

   AST_FILL_REACHES_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == C_TAIL && $past(st) == C_FILL) |-> (len == LEN_W'(MIN_FRAME))); // R1

   AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt && $past(pkt)) |-> $stable(mode));                             // R5
endmodule

bind tx_fcs_pad_stage tx_fcs_pad_stage_chk #(
   .MIN_FRAME (MIN_FRAME),
   .LEN_W     (LEN_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .st      (st_q),
   .mode    (mode_q),
   .pkt     (pkt_q),
   .len     (len_q),
   .s_ready (s_ready),
   .m_valid (m_valid),
   .m_ready (m_ready),
   .m_data  (m_data)
);

// File: tb/tx_fcs_pad_stage_test.sv
module tx_fcs_pad_stage_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       s_valid, s_ready, s_last, s_seg;
   logic [7:0] s_data;
   logic [1:0] s_mode;
   logic       m_valid, m_ready, m_last;
   logic [7:0] m_data;

   int n_run  = 0;
   int n_fail = 0;

   logic [7:0] pkt_in[$];
   logic [7:0] exp_q[$];
   logic [7:0] got_q[$];

   always #5 clk = ~clk;

   tx_fcs_pad_stage uut (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
      .s_mode(s_mode), .s_seg(s_seg),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // bit-serial reflected CRC-32 over exp_q as it stands
   function automatic logic [31:0] ref_fcs();
      logic [31:0] c = 32'hFFFF_FFFF;
      foreach (exp_q[i]) begin
         for (int k = 0; k < 8; k++) begin
            logic fb = c[0] ^ exp_q[i][k];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
         end
      end
      return ~c;
   endfunction

   task automatic build_expected(input int eff, input int len);
      logic [31:0] f;
      exp_q.delete();
      case (eff)
         0: begin
            foreach (pkt_in[i]) exp_q.push_back(pkt_in[i]);
            while (exp_q.size() < 60) exp_q.push_back(8'h00);
         end
         3: for (int i = 0; i < len - 4; i++) exp_q.push_back(pkt_in[i]);
         default: foreach (pkt_in[i]) exp_q.push_back(pkt_in[i]);
      endcase
      if (eff != 2) begin
         f = ref_fcs();
         for (int b = 0; b < 4; b++) exp_q.push_back(f[8*b +: 8]);
      end
   endtask

   task automatic run_pkt(input int len, input int mode, input bit seg,
                          input bit bp, input int seed, input string req);
      int  sent = 0;
      int  leak = 0;
      int  cyc  = 0;
      bit  done = 0;
      int  mism = -1;
      int  eff;
      pkt_in.delete();
      for (int i = 0; i < len; i++)
         pkt_in.push_back((seed < 0) ? 8'(8'h31 + i) : 8'(seed * 7 + i * 13 + 1));
      eff = seg ? 0 : mode;
      build_expected(eff, len);
      got_q.delete();
      while (!done && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (sent < len) begin
            s_valid = bp ? ((cyc % 5) != 3) : 1'b1;
            s_data  = pkt_in[sent];
            s_last  = (sent == len - 1);
            // code and flag flipped after the first byte (R5)
            s_mode  = (sent == 0) ? 2'(mode) : ~2'(mode);
            s_seg   = (sent == 0) ? seg : !seg;
         end else begin
            s_valid = 1'b1;
            s_data  = 8'hA5;
            s_last  = 1'b0;
            s_mode  = 2'b10;
            s_seg   = 1'b0;
         end
         m_ready = bp ? (((cyc * 3) % 7) < 4) : 1'b1;
         #1;
         if (s_valid && s_ready) begin
            if (sent < len) sent++;
            else leak++;
         end
         if (m_valid && m_ready) begin
            got_q.push_back(m_data);
            if (m_last) done = 1;
         end
      end
      @(negedge clk);
      s_valid = 1'b0;
      s_last  = 1'b0;
      m_ready = 1'b1;
      check(done, req, $sformatf("len %0d code %0d seg %0d bp %0d last marker seen", len, mode, seg, bp),
            int'(done), 1);
      check(got_q.size() == exp_q.size(), req,
            $sformatf("len %0d code %0d seg %0d bp %0d output length", len, mode, seg, bp),
            got_q.size(), exp_q.size());
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
         if (mism < 0 && got_q[i] !== exp_q[i]) mism = i;
      check(mism < 0, req,
            $sformatf("len %0d code %0d seg %0d bp %0d first bad byte index %0d", len, mode, seg, bp, mism),
            (mism < 0) ? 0 : int'(got_q[mism]), (mism < 0) ? 0 : int'(exp_q[mism]));
      if (bp)
         check(leak == 0, "R8", $sformatf("input taken during tail, code %0d len %0d", mode, len),
               leak, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int lens[9] = '{1, 2, 4, 5, 8, 59, 60, 61, 70};
      string tags[4] = '{"R1", "R2", "R3", "R4"};
      rst_n   = 1'b0;
      s_valid = 1'b0;
      s_data  = '0;
      s_last  = 1'b0;
      s_mode  = 2'b00;
      s_seg   = 1'b0;
      m_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(m_valid == 1'b0, "R9", "output valid after reset", int'(m_valid), 0);
      check(s_ready == 1'b1, "R9", "input ready after reset", int'(s_ready), 1);

      // R7: known check value of "123456789"
      run_pkt(9, 1, 1'b0, 1'b0, -1, "R7");
      check(got_q.size() == 13 && got_q[9] == 8'h26 && got_q[10] == 8'h39 &&
            got_q[11] == 8'hF4 && got_q[12] == 8'hCB, "R7", "check bytes of 123456789",
            (got_q.size() == 13) ? int'({got_q[12], got_q[11], got_q[10], got_q[9]}) : 0,
            32'hCBF4_3926);

      // sweep of codes, lengths and back-pressure
      for (int m = 0; m < 4; m++)
         for (int l = 0; l < 9; l++)
            for (int b = 0; b < 2; b++)
               run_pkt(lens[l], m, 1'b0, b[0], m * 9 + l, tags[m]);

      // R6: segmentation flag forces pad and append
      for (int m = 1; m < 4; m++) begin
         run_pkt(5, m, 1'b1, 1'b0, 40 + m, "R6");
         run_pkt(64, m, 1'b1, 1'b1, 50 + m, "R6");
      end

      // R5: late code changes ignored
      run_pkt(20, 1, 1'b0, 1'b0, 61, "R5");
      run_pkt(9, 2, 1'b0, 1'b1, 62, "R5");
      run_pkt(12, 3, 1'b0, 1'b0, 63, "R5");

      // R8: padding and check tail under heavy stalls
      run_pkt(10, 0, 1'b0, 1'b1, 70, "R8");
      run_pkt(3, 3, 1'b0, 1'b1, 71, "R8");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule